// File: doc/BRIEF.md
# SPI Master Transaction Sequencer

This block is a single-lane SPI master. A host drives it through a small word-addressed register port. The host loads bytes into a transmit FIFO and programs a transfer-control word, which holds a 4-bit mode, a write count and a read count. A write to the command register then launches one transaction. Chip select stays low for the whole transaction. The sequencer walks through up to three phases (write, read, simultaneous write/read, or an 8-clock dummy) in the order the mode selects. It shifts bytes MSB first in SPI mode 0 and places received bytes in a receive FIFO.

The serial clock is derived from the core clock by a programmable divider. If the transmit FIFO runs dry during a write phase, the shifter waits with SCLK low. It also waits before a read byte when the receive FIFO is full, so no byte is ever lost. The FIFO and sequencer resets are one-shot control bits that clear themselves. A status word reports busy, transmit-empty and both fill levels.

Top module: `spim_core`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk and spi_mosi are 0, both FIFOs are empty, and the status word reads 32'h0040_0000.
- R2: A command write (address 2) starts a transaction only when the block is idle and has been armed by a transfer-control write since the last start or core reset; otherwise it is ignored. Busy (status bit 0) is set from the start until the last phase ends, and spi_cs_n falls exactly once per transaction and stays low throughout.
- R3: The mode field is bits 27:24 of the transfer-control word (address 1). Its codes select these phase orders: 0 simultaneous write/read; 1 write; 2 read; 3 write then read; 4 read then write; 5 write, dummy, read; 6 read, dummy, write; 7 no data; 8 dummy then write; 9 dummy then read. Codes 10 to 15 behave as code 7.
- R4: The write count (bits 20:12) and the read count (bits 8:0) hold bytes minus one. A write phase and a simultaneous phase transfer write count + 1 bytes. A read phase transfers read count + 1 bytes. A dummy phase is exactly 8 SCLK cycles with MOSI low.
- R5: The bus uses SPI mode 0, MSB first. SCLK idles low, MOSI changes only while SCLK is low, and MISO is sampled on the SCLK rising edge. Each SCLK high time lasts div + 1 core clocks, where div is bits 7:0 of the divider register (address 5).
- R6: Only read-phase and simultaneous-phase bytes enter the receive FIFO. Bytes sampled during write and dummy phases are discarded. The MOSI byte sent in read and dummy phases is 8'h00.
- R7: When the transmit FIFO is empty at the start of a write byte, SCLK stays low and the transaction stays busy until the host pushes data. The transaction then resumes with no byte lost.
- R8: When the receive FIFO is full at the start of a read byte, the transaction pauses with SCLK low until the host pops an entry. No received byte is dropped.
- R9: Control register (address 0) bit 2 empties the transmit FIFO, bit 1 empties the receive FIFO, and bit 0 returns the sequencer to idle (spi_cs_n high) and clears the armed state. Each bit reads back as 1 in the cycle after the write and as 0 one cycle later.
- R10: The status word (address 4) has bit 0 busy, bit 22 transmit FIFO empty, bits 20:16 the transmit entry count and bits 12:8 the receive entry count. All other bits are zero.
- R11: A data write (address 3) pushes a byte into the transmit FIFO and is dropped when the FIFO is full. A data read returns the oldest received byte and pops it. The transfer-control word reads back with only its mode and count fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO at address 3) |
| reg_addr | input | 3 | Word register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the peripheral |
| spi_miso | input | 1 | Serial data from the peripheral |

## Verification
The assertions assume that the divider register stays constant while a transaction is busy. A smaller value written mid-byte would let the divider counter run past its terminal value. They also assume the host never raises reg_wr and reg_rd in the same cycle. The bench writes the divider only between transactions and drives one register access at a time through its tasks. Its peripheral model changes MISO only on SCLK falling edges and on the chip-select fall, which matches the sampling point the shifter relies on.

// File: rtl/spim_pkg.sv
package spim_pkg;
   localparam int CNT_W    = 9;
   localparam int MODE_LSB = 24;
   localparam int WCNT_LSB = 12;
   localparam int RCNT_LSB = 0;

   localparam logic [2:0] ADDR_CTRL   = 3'd0;
   localparam logic [2:0] ADDR_XFER   = 3'd1;
   localparam logic [2:0] ADDR_CMD    = 3'd2;
   localparam logic [2:0] ADDR_DATA   = 3'd3;
   localparam logic [2:0] ADDR_STATUS = 3'd4;
   localparam logic [2:0] ADDR_DIV    = 3'd5;

   typedef enum logic [2:0] {PH_END, PH_WR, PH_RD, PH_WRRD, PH_DUM} phase_e;
   typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOAD, S_SHIFT, S_DONE} seq_state_e;

   // Phase k of the given mode; PH_END terminates the list.
   function automatic phase_e phase_at(input logic [3:0] mode, input logic [1:0] idx);
      phase_e p0, p1, p2;
      p0 = PH_END; p1 = PH_END; p2 = PH_END;
      case (mode)
         4'd0: p0 = PH_WRRD;
         4'd1: p0 = PH_WR;
         4'd2: p0 = PH_RD;
         4'd3: begin p0 = PH_WR;  p1 = PH_RD; end
         4'd4: begin p0 = PH_RD;  p1 = PH_WR; end
         4'd5: begin p0 = PH_WR;  p1 = PH_DUM; p2 = PH_RD; end
         4'd6: begin p0 = PH_RD;  p1 = PH_DUM; p2 = PH_WR; end
         4'd8: begin p0 = PH_DUM; p1 = PH_WR; end
         4'd9: begin p0 = PH_DUM; p1 = PH_RD; end
         default: ;
      endcase
      case (idx)
         2'd0:    return p0;
         2'd1:    return p1;
         2'd2:    return p2;
         default: return PH_END;
      endcase
   endfunction
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       push,
   input  logic [W-1:0]               wdata,
   input  logic                       pop,
   output logic [W-1:0]               rdata,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       full,
   output logic                       empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spim_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0; rp <= '0; count <= '0;
      end else if (clr) begin
         wp <= '0; rp <= '0; count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end
endmodule

// File: rtl/spim_seq.sv
module spim_seq
   import spim_pkg::*;
#(
   parameter int DIVW = 8,
   parameter int CNTW = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            soft_rst,
   input  logic            start,
   input  logic [3:0]      mode,
   input  logic [CNTW-1:0] wcnt,
   input  logic [CNTW-1:0] rcnt,
   input  logic [DIVW-1:0] div,
   input  logic            tx_empty,
   input  logic [7:0]      tx_data,
   output logic            tx_pop,
   input  logic            rx_full,
   output logic            rx_push,
   output logic [7:0]      rx_data,
   output logic            busy,
   output logic            cs_n,
   output logic            sclk,
   output logic            mosi,
   input  logic            miso
);
   seq_state_e      st;
   logic [1:0]      ph_idx;
   logic [CNTW-1:0] byte_cnt, wcnt_q, rcnt_q, ph_last;
   logic [2:0]      bit_cnt;
   logic [DIVW-1:0] div_cnt;
   logic [3:0]      mode_q;
   logic [7:0]      sh_out, sh_in;
   logic            sclk_q;
   phase_e          cur_ph;
   logic            need_tx, need_rx, can_go, half_tick, byte_end;

   assign cur_ph    = phase_at(mode_q, ph_idx);
   assign need_tx   = (cur_ph == PH_WR) || (cur_ph == PH_WRRD);
   assign need_rx   = (cur_ph == PH_RD) || (cur_ph == PH_WRRD);
   assign ph_last   = (cur_ph == PH_DUM) ? '0 : (need_tx ? wcnt_q : rcnt_q);
   assign can_go    = !(need_tx && tx_empty) && !(need_rx && rx_full);
   assign half_tick = (st == S_SHIFT) && (div_cnt == div);
   assign byte_end  = half_tick && sclk_q && (bit_cnt == 3'd7);

   assign tx_pop  = (st == S_LOAD) && (cur_ph != PH_END) && need_tx && can_go;
   assign rx_push = byte_end && need_rx;
   assign rx_data = sh_in;
   assign busy    = (st != S_IDLE);
   assign cs_n    = (st == S_IDLE);
   assign sclk    = sclk_q;
   assign mosi    = (st == S_SHIFT) ? sh_out[7] : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE; ph_idx <= '0; byte_cnt <= '0; bit_cnt <= '0; div_cnt <= '0;
         mode_q <= '0; wcnt_q <= '0; rcnt_q <= '0; sh_out <= '0; sh_in <= '0; sclk_q <= 1'b0;
      end else if (soft_rst) begin
         st <= S_IDLE; ph_idx <= '0; byte_cnt <= '0; bit_cnt <= '0; div_cnt <= '0;
         sclk_q <= 1'b0;
      end else begin
         case (st)
            S_IDLE: if (start) begin
               mode_q <= mode; wcnt_q <= wcnt; rcnt_q <= rcnt;
               ph_idx <= '0; byte_cnt <= '0;
               st <= S_SETUP;
            end
            S_SETUP: st <= S_LOAD;
            S_LOAD: begin
               if (cur_ph == PH_END) begin
                  st <= S_DONE;
               end else if (can_go) begin
                  sh_out  <= need_tx ? tx_data : 8'h00;
                  bit_cnt <= '0;
                  div_cnt <= '0;
                  st      <= S_SHIFT;
               end
            end
            S_SHIFT: begin
               if (!half_tick) begin
                  div_cnt <= div_cnt + 1'b1;
               end else begin
                  div_cnt <= '0;
                  if (!sclk_q) begin
                     sclk_q <= 1'b1;
                     sh_in  <= {sh_in[6:0], miso};
                  end else begin
                     sclk_q <= 1'b0;
                     if (bit_cnt == 3'd7) begin
                        if (byte_cnt == ph_last) begin
                           ph_idx   <= ph_idx + 1'b1;
                           byte_cnt <= '0;
                        end else begin
                           byte_cnt <= byte_cnt + 1'b1;
                        end
                        st <= S_LOAD;
                     end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        sh_out  <= {sh_out[6:0], 1'b0};
                     end
                  end
               end
            end
            S_DONE:  st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   // R5: data to the peripheral holds still while the clock is high
   a_r5_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_q |-> $stable(mosi));
   // R2: no clock activity outside a transaction
   a_r2_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk_q);
   // R7: never pull a byte from an empty transmit FIFO
   a_r7_no_tx_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |-> !tx_empty);
   // R8: never push a byte into a full receive FIFO
   a_r8_no_rx_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> !rx_full);
endmodule

// File: rtl/spim_core.sv
module spim_core
   import spim_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int DIV_W      = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        spi_cs_n,
   output logic        spi_sclk,
   output logic        spi_mosi,
   input  logic        spi_miso
);
   localparam int FCW = $clog2(FIFO_DEPTH + 1);

   if (FCW > 5) begin : g_bad_fifo
      $error("spim_core: FIFO_DEPTH must fit the 5-bit status count fields");
   end
   if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
      $error("spim_core: DIV_W must be between 1 and 8");
   end

   logic [2:0]       ctrl_q;
   logic [3:0]       mode_q;
   logic [CNT_W-1:0] wcnt_q, rcnt_q;
   logic [DIV_W-1:0] div_q;
   logic             armed_q, busy, start_ok;
   logic             core_rst, tx_clr, rx_clr;
   logic             tx_pop, tx_empty, tx_full, rx_push, rx_full, rx_empty;
   logic [7:0]       tx_data, rx_wdata, rx_rdata;
   logic [FCW-1:0]   tx_cnt, rx_cnt;
   logic             wr_ctrl, wr_xfer, wr_cmd, wr_data, wr_div, rd_data;
   logic             unused_ok;

   assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
   assign wr_xfer = reg_wr && (reg_addr == ADDR_XFER);
   assign wr_cmd  = reg_wr && (reg_addr == ADDR_CMD);
   assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
   assign wr_div  = reg_wr && (reg_addr == ADDR_DIV);
   assign rd_data = reg_rd && (reg_addr == ADDR_DATA);

   assign core_rst = ctrl_q[0];
   assign rx_clr   = ctrl_q[1];
   assign tx_clr   = ctrl_q[2];
   assign start_ok = wr_cmd && armed_q && !busy && !core_rst;
   assign unused_ok = ^{reg_wdata[31:28], reg_wdata[23:21], reg_wdata[11:9]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0; mode_q <= '0; wcnt_q <= '0; rcnt_q <= '0;
         div_q <= '0; armed_q <= 1'b0;
      end else begin
         ctrl_q <= wr_ctrl ? reg_wdata[2:0] : 3'b000;
         if (wr_xfer) begin
            mode_q <= reg_wdata[MODE_LSB +: 4];
            wcnt_q <= reg_wdata[WCNT_LSB +: CNT_W];
            rcnt_q <= reg_wdata[RCNT_LSB +: CNT_W];
         end
         if (wr_div) div_q <= reg_wdata[DIV_W-1:0];
         if (core_rst || start_ok) armed_q <= 1'b0;
         else if (wr_xfer)         armed_q <= 1'b1;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_CTRL: reg_rdata[2:0] = ctrl_q;
         ADDR_XFER: begin
            reg_rdata[MODE_LSB +: 4]     = mode_q;
            reg_rdata[WCNT_LSB +: CNT_W] = wcnt_q;
            reg_rdata[RCNT_LSB +: CNT_W] = rcnt_q;
         end
         ADDR_DATA: reg_rdata[7:0] = rx_rdata;
         ADDR_STATUS: begin
            reg_rdata[0]     = busy;
            reg_rdata[22]    = tx_empty;
            reg_rdata[20:16] = 5'(tx_cnt);
            reg_rdata[12:8]  = 5'(rx_cnt);
         end
         ADDR_DIV: reg_rdata[DIV_W-1:0] = div_q;
         default: ;
      endcase
   end

   spim_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
      .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(wr_data), .wdata(reg_wdata[7:0]),
      .pop(tx_pop), .rdata(tx_data), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

   spim_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push), .wdata(rx_wdata),
      .pop(rd_data), .rdata(rx_rdata), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

   spim_seq #(.DIVW(DIV_W), .CNTW(CNT_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .soft_rst(core_rst), .start(start_ok),
      .mode(mode_q), .wcnt(wcnt_q), .rcnt(rcnt_q), .div(div_q),
      .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
      .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_wdata),
      .busy(busy), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso));

   // R2: an accepted command makes the sequencer busy on the next cycle
   a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start_ok |=> busy);
   // R9: the core reset bit leaves the sequencer idle
   a_r9_core_reset_idles: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst |=> !busy);
   // R9: the transmit FIFO reset bit empties the FIFO
   a_r9_tx_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      tx_clr |=> tx_empty);
   // R11: a data read never pops an empty receive FIFO into a wrong count
   a_r11_rx_pop_counts: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !rx_empty && !rx_push && !rx_clr) |=> (rx_cnt == $past(rx_cnt) - 1'b1));
   // R11: a full transmit FIFO drops further data writes
   a_r11_tx_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && tx_full && !tx_pop && !tx_clr) |=> $stable(tx_cnt));
endmodule

// File: tb/spim_core_tb.sv
module spim_core_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [2:0] A_CTRL = 3'd0, A_XFER = 3'd1, A_CMD = 3'd2,
                          A_DATA = 3'd3, A_STAT = 3'd4, A_DIV = 3'd5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        spi_cs_n, spi_sclk, spi_mosi;
   logic        spi_miso = 1'b0;

   int tests = 0, fails = 0;

   spim_core dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

   always #(CLK_PERIOD/2) clk = ~clk;

   // ---------------- peripheral model ----------------
   int         sbit = 0, rises = 0, nm = 0, csfalls = 0;
   logic [7:0] msh = '0;
   logic [7:0] mlog [0:63];
   logic [7:0] b0, b1;

   function automatic logic [7:0] sbyte(input int s);
      return 8'((s * 29 + 7) ^ 8'h5A);
   endfunction
   function automatic logic [7:0] tpat(input int k);
      return 8'(k * 53 + 8'h96);
   endfunction

   always @(negedge spi_cs_n) begin
      sbit = 0; b0 = sbyte(0); spi_miso = b0[7]; csfalls++;
   end
   always @(negedge spi_sclk) if (!spi_cs_n) begin
      sbit++; b1 = sbyte(sbit / 8); spi_miso = b1[7 - (sbit % 8)];
   end
   always @(posedge spi_sclk) if (!spi_cs_n) begin
      msh = {msh[6:0], spi_mosi}; rises++;
      if (rises % 8 == 0 && nm < 64) begin mlog[nm] = msh; nm++; end
   end

   // clock-shape monitor, sampled away from the active edge
   int   hi_run = 0, last_hi = 0, mosi_bad = 0;
   logic p_sclk = 1'b0, p_mosi = 1'b0;
   always @(negedge clk) begin
      if (spi_sclk && p_sclk && spi_mosi !== p_mosi) mosi_bad++;
      if (spi_sclk) hi_run++;
      else if (p_sclk) begin last_hi = hi_run; hi_run = 0; end
      p_sclk = spi_sclk; p_mosi = spi_mosi;
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic idle_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_idle(input string req);
      logic [31:0] s;
      bit done = 0;
      for (int i = 0; i < 20000 && !done; i++) begin
         reg_read(A_STAT, s);
         if (!s[0]) done = 1;
      end
      chk(done, req, s, 32'h0);
   endtask

   function automatic logic [31:0] xword(input int mode, input int wc, input int rc);
      return (32'(mode) << 24) | (32'(wc) << 12) | 32'(rc);
   endfunction

   int kinds [0:63];
   int nslots;

   task automatic add_ph(input int k, input int n);
      for (int i = 0; i < n; i++) begin kinds[nslots] = k; nslots++; end
   endtask

   // 1 write, 2 read, 3 simultaneous, 4 dummy
   task automatic build_slots(input int mode, input int wc, input int rc);
      nslots = 0;
      case (mode)
         0: add_ph(3, wc + 1);
         1: add_ph(1, wc + 1);
         2: add_ph(2, rc + 1);
         3: begin add_ph(1, wc + 1); add_ph(2, rc + 1); end
         4: begin add_ph(2, rc + 1); add_ph(1, wc + 1); end
         5: begin add_ph(1, wc + 1); add_ph(4, 1); add_ph(2, rc + 1); end
         6: begin add_ph(2, rc + 1); add_ph(4, 1); add_ph(1, wc + 1); end
         8: begin add_ph(4, 1); add_ph(1, wc + 1); end
         9: begin add_ph(4, 1); add_ph(2, rc + 1); end
         default: ;
      endcase
   endtask

   task automatic clear_logs();
      rises = 0; nm = 0; csfalls = 0; msh = '0;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      logic [31:0] d;
      reg_read(A_STAT, d);
      chk(d == 32'h0040_0000, "R1 status after reset", d, 32'h0040_0000);
      chk({spi_cs_n, spi_sclk, spi_mosi} == 3'b100, "R1 pins after reset",
          {29'd0, spi_cs_n, spi_sclk, spi_mosi}, 32'd4);
      reg_read(A_CTRL, d);
      chk(d == 0, "R1 control after reset", d, 0);
      reg_write(A_XFER, 32'hFFFF_FFFF);
      reg_read(A_XFER, d);
      chk(d == 32'h0F1F_F1FF, "R11 transfer word readback", d, 32'h0F1F_F1FF);
      reg_write(A_CTRL, 32'h1);   // drop the arm left by the readback test
      idle_cycles(1);
   endtask

   task automatic run_xfer(input int mode, input int wc, input int rc);
      logic [31:0] d;
      int ntx = 0, widx = 0, nrx = 0, bad = 0;
      logic [7:0] expb;
      build_slots(mode, wc, rc);
      for (int s = 0; s < nslots; s++) begin
         if (kinds[s] == 1 || kinds[s] == 3) ntx++;
         if (kinds[s] == 2 || kinds[s] == 3) nrx++;
      end
      clear_logs();
      for (int k = 0; k < ntx; k++) reg_write(A_DATA, {24'd0, tpat(k)});
      reg_write(A_XFER, xword(mode, wc, rc));
      reg_write(A_CMD, 32'h1);
      wait_idle($sformatf("R2 mode %0d finishes", mode));
      chk(csfalls == 1, $sformatf("R2 mode %0d single select", mode), csfalls, 1);
      chk(rises == 8 * nslots, $sformatf("R3 R4 mode %0d clock count", mode), rises, 8 * nslots);
      for (int s = 0; s < nslots && s < nm; s++) begin
         expb = (kinds[s] == 1 || kinds[s] == 3) ? tpat(widx) : 8'h00;
         if (kinds[s] == 1 || kinds[s] == 3) widx++;
         if (mlog[s] !== expb && bad == 0) begin
            bad = 1;
            chk(0, $sformatf("R4 R6 mode %0d MOSI byte %0d", mode, s), mlog[s], expb);
         end
      end
      if (bad == 0) chk(1, "R4 MOSI bytes", 0, 0);
      reg_read(A_STAT, d);
      chk(d == ({20'd0, 5'(nrx), 8'd0} | 32'h0040_0000),
          $sformatf("R10 R6 mode %0d status after run", mode), d,
          {20'd0, 5'(nrx), 8'd0} | 32'h0040_0000);
      bad = 0;
      for (int s = 0; s < nslots; s++) begin
         if (kinds[s] == 2 || kinds[s] == 3) begin
            reg_read(A_DATA, d);
            if (d[7:0] !== sbyte(s) && bad == 0) begin
               bad = 1;
               chk(0, $sformatf("R6 mode %0d RX byte of slot %0d", mode, s), d, {24'd0, sbyte(s)});
            end
         end
      end
      if (bad == 0) chk(1, "R6 RX bytes", 0, 0);
   endtask

   task automatic t_modes();
      reg_write(A_DIV, 32'd0);
      run_xfer(0, 3, 0);
      run_xfer(1, 2, 0);
      run_xfer(2, 0, 3);
      run_xfer(3, 1, 2);
      run_xfer(4, 2, 1);
      run_xfer(5, 1, 1);
      run_xfer(6, 1, 2);
      run_xfer(7, 0, 0);
      run_xfer(8, 1, 0);
      run_xfer(9, 0, 2);
      run_xfer(12, 2, 2);
   endtask

   task automatic t_timing();
      mosi_bad = 0;
      reg_write(A_DIV, 32'd2);
      run_xfer(1, 1, 0);
      chk(last_hi == 3, "R5 SCLK high time with div 2", last_hi, 3);
      reg_write(A_DIV, 32'd0);
      run_xfer(3, 0, 0);
      chk(last_hi == 1, "R5 SCLK high time with div 0", last_hi, 1);
      chk(mosi_bad == 0, "R5 MOSI stable while SCLK high", mosi_bad, 0);
   endtask

   task automatic t_underflow();
      logic [31:0] d;
      clear_logs();
      reg_write(A_DATA, {24'd0, tpat(0)});
      reg_write(A_XFER, xword(1, 3, 0));
      reg_write(A_CMD, 32'h1);
      idle_cycles(200);
      reg_read(A_STAT, d);
      chk(d == 32'h0040_0001, "R7 R10 status during TX stall", d, 32'h0040_0001);
      chk(nm == 1 && spi_sclk == 1'b0, "R7 one byte then SCLK held low", nm, 1);
      for (int k = 1; k < 4; k++) reg_write(A_DATA, {24'd0, tpat(k)});
      wait_idle("R7 resumes after refill");
      chk(nm == 4, "R7 byte count after resume", nm, 4);
      for (int k = 0; k < 4 && k < nm; k++)
         chk(mlog[k] == tpat(k), $sformatf("R7 byte %0d after stall", k), mlog[k], tpat(k));
   endtask

   task automatic t_rx_full();
      logic [31:0] d;
      int bad = 0;
      clear_logs();
      reg_write(A_XFER, xword(2, 0, 19));
      reg_write(A_CMD, 32'h1);
      idle_cycles(600);
      reg_read(A_STAT, d);
      chk(d == 32'h0040_1001, "R8 R10 status with RX full", d, 32'h0040_1001);
      chk(rises == 128, "R8 shifting paused at 16 bytes", rises, 128);
      for (int s = 0; s < 16; s++) begin
         reg_read(A_DATA, d);
         if (d[7:0] !== sbyte(s) && bad == 0) begin
            bad = 1; chk(0, $sformatf("R8 byte %0d", s), d, {24'd0, sbyte(s)});
         end
      end
      wait_idle("R8 completes after drain");
      for (int s = 16; s < 20; s++) begin
         reg_read(A_DATA, d);
         if (d[7:0] !== sbyte(s) && bad == 0) begin
            bad = 1; chk(0, $sformatf("R8 byte %0d", s), d, {24'd0, sbyte(s)});
         end
      end
      if (bad == 0) chk(1, "R8 all 20 bytes kept", 0, 0);
      reg_read(A_STAT, d);
      chk(d == 32'h0040_0000, "R8 FIFOs empty afterwards", d, 32'h0040_0000);
   endtask

   task automatic t_resets();
      logic [31:0] d;
      for (int k = 0; k < 3; k++) reg_write(A_DATA, 32'h55);
      reg_read(A_STAT, d);
      chk(d == 32'h0003_0000, "R10 status with three TX entries", d, 32'h0003_0000);
      reg_write(A_CTRL, 32'h4);
      reg_read(A_CTRL, d);
      chk(d == 32'h4, "R9 TX reset bit pending", d, 32'h4);
      reg_read(A_CTRL, d);
      chk(d == 32'h0, "R9 TX reset bit self-clears", d, 32'h0);
      reg_read(A_STAT, d);
      chk(d == 32'h0040_0000, "R9 TX FIFO emptied", d, 32'h0040_0000);
      // leave three bytes in the RX FIFO then clear it
      reg_write(A_XFER, xword(2, 0, 2));
      reg_write(A_CMD, 32'h1);
      wait_idle("R9 read run completes");
      reg_read(A_STAT, d);
      chk(d[12:8] == 5'd3, "R9 RX holds three bytes", d, 32'h0040_0300);
      reg_write(A_CTRL, 32'h2);
      reg_read(A_CTRL, d);
      chk(d == 32'h2, "R9 RX reset bit pending", d, 32'h2);
      reg_read(A_STAT, d);
      chk(d == 32'h0040_0000, "R9 RX FIFO emptied", d, 32'h0040_0000);
      // stall a write with no data, then core reset
      reg_write(A_XFER, xword(1, 0, 0));
      reg_write(A_CMD, 32'h1);
      idle_cycles(20);
      chk(spi_cs_n == 1'b0, "R7 stalled transaction keeps select low", spi_cs_n, 0);
      reg_write(A_CTRL, 32'h1);
      idle_cycles(1);
      reg_read(A_STAT, d);
      chk(d == 32'h0040_0000 && spi_cs_n, "R9 core reset returns to idle", d, 32'h0040_0000);
      clear_logs();
      reg_write(A_CMD, 32'h1);
      idle_cycles(20);
      reg_read(A_STAT, d);
      chk(d[0] == 1'b0 && csfalls == 0, "R2 command without arming ignored", d, 32'h0040_0000);
      // busy ignores a second command
      reg_write(A_DATA, 32'hA5);
      reg_write(A_XFER, xword(1, 0, 0));
      clear_logs();
      reg_write(A_CMD, 32'h1);
      reg_write(A_CMD, 32'h1);
      wait_idle("R2 run after repeated command");
      idle_cycles(20);
      chk(csfalls == 1 && nm == 1, "R2 command while busy ignored", csfalls, 1);
   endtask

   // ---------------- main ----------------
   initial begin
      #(CLK_PERIOD * 150000);
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_modes();
      t_timing();
      t_underflow();
      t_rx_full();
      t_resets();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule